// File: doc/BRIEF.md
# Frame Rate Calibration Divider

This block sets the display frame rate from a clock using a host-timed measurement. The host raises a calibration enable bit to open a measuring window and clears it to close the window. While the window is open, the block counts clock cycles. When the window closes, it converts the count into a small pre-divider ratio. The frame timer then divides the clock by that ratio and by a fixed line factor of 1088, and emits one frame-start pulse per frame. A longer window gives a larger ratio and so a lower frame rate. This lets the host trade refresh rate against current consumption without ever writing the ratio directly.

Measurement is refused while the display is powered down or showing a partial screen. If either mode is entered while a window is open, that measurement is dropped. A freshly measured ratio waits for the end of the frame in progress, so a frame is never cut short. Reset is asserted asynchronously and released on the clock through a two-stage synchronizer.

Top module: `frame_rate_cal`

## Requirements
- R1: While reset is asserted and right after it, `ratio` reads 4, `cal_busy` is low and `frame_tick` is low. The first frames then run with ratio 4.
- R2: A window opens only on a low-to-high change of `cal_en`. `cal_busy` is high from the clock edge that samples `cal_en` high. It falls at the edge that samples `cal_en` low.
- R3: When a window closes, N is the number of clock edges at which `cal_en` was sampled high. The measured ratio is floor((N + 8) / 16), so 64 edges give 4.
- R4: The measured ratio is clamped to the range 1 to 15. A quotient of 0 becomes 1, and a quotient above 15 becomes 15. `ratio` never leaves 1..15.
- R5: A rising `cal_en` while `pwr_down` or `partial_mode` is high opens no window. `cal_busy` stays low and `ratio` is unchanged.
- R6: If `pwr_down` or `partial_mode` goes high while a window is open, the window ends at that edge and `cal_busy` falls. The previous ratio is kept.
- R7: `frame_tick` is a one-cycle pulse. The distance between successive pulses is `ratio` × 1088 clock cycles.
- R8: A newly measured ratio is applied at the next `frame_tick`. The frame in progress completes with the old ratio, and `ratio` changes only at the edge that ends a frame.
- R9: Keeping `cal_en` high after a refused start does not open a window once the blocking mode clears. `cal_en` must go low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock to be divided and measured |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Calibration enable bit; high holds the window open |
| pwr_down | input | 1 | Power-down mode flag; blocks calibration |
| partial_mode | input | 1 | Partial-screen mode flag; blocks calibration |
| ratio | output | 4 | Pre-divider ratio in use, 1..15 |
| frame_tick | output | 1 | One-cycle pulse at each frame start |
| cal_busy | output | 1 | High while a calibration window is open |

## Verification
A wrong window count or a wrong rounding step appears at the ports only one frame later. It shows as a `ratio` value that differs from the expected value after the next `frame_tick`, and as a tick spacing that differs from ratio × 1088. A faulty frame timer appears within one frame as a wrong pulse spacing. A ratio that is applied too early is caught by measuring the frame during which a new window was closed. Window-state faults, such as a missed abort or a start that should have been refused, appear in `cal_busy` one cycle after the stimulus.

// File: rtl/frc_pkg.sv
package frc_pkg;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;

  localparam int unsigned FRC_RATIO_W = 4;

endpackage

// File: rtl/frc_reset_sync.sv
module frc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/frc_cal_window.sv
module frc_cal_window
  import frc_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_en_i,
  input  logic             blocked_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);

  win_state_e       state_q, state_d;
  logic             cal_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             start;
  logic             done;

  // Next-state logic: opening, counting, closing and aborting the window
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    done    = 1'b0;
    start   = cal_en_i && !cal_q && !blocked_i;
    case (state_q)
      WIN_IDLE: begin
        if (start) begin
          state_d = WIN_OPEN;
          cnt_d   = CNT_W'(1);
          cnt_en  = 1'b1;
        end
      end
      WIN_OPEN: begin
        if (blocked_i) begin
          state_d = WIN_IDLE;
        end else if (!cal_en_i) begin
          state_d = WIN_IDLE;
          done    = 1'b1;
        end else if (cnt_q != {CNT_W{1'b1}}) begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      cal_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cal_q   <= cal_en_i;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy_o  = (state_q == WIN_OPEN);
  assign done_o  = done;
  assign count_o = cnt_q;

  // R5
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(cal_en_i && !blocked_i));

  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && blocked_i) |=> !busy_o);

  // R2
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cal_en_i) |=> !busy_o);

endmodule

// File: rtl/frc_ratio_quant.sv
module frc_ratio_quant #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned RATIO_W    = 4,
  parameter int unsigned UNIT_SHIFT = 4,
  parameter int unsigned RATIO_MIN  = 1,
  parameter int unsigned RATIO_MAX  = 15
) (
  input  logic [CNT_W-1:0]   count_i,
  output logic [RATIO_W-1:0] ratio_o
);

  localparam int unsigned QW   = CNT_W + 1;
  localparam int unsigned HALF = (UNIT_SHIFT > 0) ? (1 << (UNIT_SHIFT - 1)) : 0;

  logic [QW-1:0] sum;
  logic [QW-1:0] quot;

  always_comb begin
    sum  = {1'b0, count_i} + QW'(HALF);
    quot = sum >> UNIT_SHIFT;
    if (quot < QW'(RATIO_MIN)) begin
      ratio_o = RATIO_W'(RATIO_MIN);
    end else if (quot > QW'(RATIO_MAX)) begin
      ratio_o = RATIO_W'(RATIO_MAX);
    end else begin
      ratio_o = quot[RATIO_W-1:0];
    end
  end

endmodule

// File: rtl/frc_frame_div.sv
module frc_frame_div #(
  parameter int unsigned RATIO_W    = 4,
  parameter int unsigned FRAME_BASE = 1088,
  parameter int unsigned RATIO_RST  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] load_ratio_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               tick_o
);

  localparam int unsigned LINE_W = $clog2(FRAME_BASE);

  logic [RATIO_W-1:0] active_q, active_d;
  logic [RATIO_W-1:0] pend_q, pend_d;
  logic               pend_vld_q, pend_vld_d;
  logic [RATIO_W-1:0] pre_q, pre_d;
  logic [LINE_W-1:0]  line_q, line_d;
  logic               pre_last, line_last, tick;

  // Next-state logic: two-stage frame timer and boundary ratio swap
  always_comb begin
    pre_last  = (pre_q == active_q - 1'b1);
    line_last = (line_q == LINE_W'(FRAME_BASE - 1));
    tick      = pre_last && line_last;

    pre_d  = pre_last ? '0 : pre_q + 1'b1;
    line_d = line_q;
    if (pre_last) begin
      line_d = line_last ? '0 : line_q + 1'b1;
    end

    active_d   = active_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    if (tick && pend_vld_q) begin
      active_d   = pend_q;
      pend_vld_d = 1'b0;
    end
    if (load_i) begin
      pend_d     = load_ratio_i;
      pend_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= RATIO_W'(RATIO_RST);
      pend_q     <= RATIO_W'(RATIO_RST);
      pend_vld_q <= 1'b0;
      pre_q      <= '0;
      line_q     <= '0;
    end else begin
      active_q   <= active_d;
      pend_vld_q <= pend_vld_d;
      pre_q      <= pre_d;
      line_q     <= line_d;
      if (load_i) begin
        pend_q <= pend_d;
      end
    end
  end

  assign ratio_o = active_q;
  assign tick_o  = tick;

  // R8
  ratio_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_o) |-> $past(tick_o));

  // R7
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/frame_rate_cal.sv
module frame_rate_cal #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned UNIT_SHIFT = 4,
  parameter int unsigned RATIO_MIN  = 1,
  parameter int unsigned RATIO_MAX  = 15,
  parameter int unsigned RATIO_RST  = 4,
  parameter int unsigned FRAME_BASE = 1088
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_en,
  input  logic       pwr_down,
  input  logic       partial_mode,
  output logic [3:0] ratio,
  output logic       frame_tick,
  output logic       cal_busy
);

  localparam int unsigned RW = frc_pkg::FRC_RATIO_W;

  logic             rst_sync_n;
  logic             blocked;
  logic             win_done;
  logic [CNT_W-1:0] win_count;
  logic [RW-1:0]    meas_ratio;

  assign blocked = pwr_down | partial_mode;

  frc_reset_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  frc_cal_window #(.CNT_W(CNT_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cal_en_i  (cal_en),
    .blocked_i (blocked),
    .busy_o    (cal_busy),
    .done_o    (win_done),
    .count_o   (win_count)
  );

  frc_ratio_quant #(
    .CNT_W      (CNT_W),
    .RATIO_W    (RW),
    .UNIT_SHIFT (UNIT_SHIFT),
    .RATIO_MIN  (RATIO_MIN),
    .RATIO_MAX  (RATIO_MAX)
  ) u_quant (
    .count_i (win_count),
    .ratio_o (meas_ratio)
  );

  frc_frame_div #(
    .RATIO_W    (RW),
    .FRAME_BASE (FRAME_BASE),
    .RATIO_RST  (RATIO_RST)
  ) u_div (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .load_i       (win_done),
    .load_ratio_i (meas_ratio),
    .ratio_o      (ratio),
    .tick_o       (frame_tick)
  );

  // R4
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ratio >= 4'(RATIO_MIN)) && (ratio <= 4'(RATIO_MAX)));

endmodule

// File: tb/tb_frame_rate_cal.sv
`timescale 1ns/1ps
module tb_frame_rate_cal;

  localparam int BASE     = 1088;
  localparam int WD_LIMIT = 190000;
  localparam int NVEC     = 9;
  localparam int WIN_LEN [0:NVEC-1] = '{24, 64, 8, 7, 23, 40, 1, 232, 300};
  localparam int WIN_EXP [0:NVEC-1] = '{ 2,  4, 1, 1,  1,  3, 1,  15,  15};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cal_en, pwr_down, partial_mode;
  logic [3:0] ratio;
  logic       frame_tick, cal_busy;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  frame_rate_cal dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cal_en       (cal_en),
    .pwr_down     (pwr_down),
    .partial_mode (partial_mode),
    .ratio        (ratio),
    .frame_tick   (frame_tick),
    .cal_busy     (cal_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      errors++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic wait_tick(output int at);
    @(negedge clk);
    while (!frame_tick) @(negedge clk);
    at = cyc;
  endtask

  // Called just after a negedge; holds cal_en high for n sampling edges
  task automatic cal_window(input int n);
    cal_en = 1'b1;
    @(negedge clk);
    check(cal_busy == 1'b1, "R2 busy after open", int'(cal_busy), 1);
    repeat (n - 1) @(negedge clk);
    cal_en = 1'b0;
    @(negedge clk);
    check(cal_busy == 1'b0, "R2 busy after close", int'(cal_busy), 0);
  endtask

  initial begin
    int t0, t1, t2;
    rst_n = 1'b0; cal_en = 1'b0; pwr_down = 1'b0; partial_mode = 1'b0;
    repeat (5) @(negedge clk);
    check(ratio == 4'd4, "R1 reset ratio", int'(ratio), 4);
    check(cal_busy == 1'b0, "R1 reset busy", int'(cal_busy), 0);
    check(frame_tick == 1'b0, "R1 reset tick", int'(frame_tick), 0);
    rst_n = 1'b1;
    wait_tick(t0);
    @(negedge clk);
    check(frame_tick == 1'b0, "R7 tick width", int'(frame_tick), 0);
    wait_tick(t1);
    check(t1 - t0 == 4 * BASE, "R1 R7 default period", t1 - t0, 4 * BASE);

    // Vector table: window length versus measured ratio (R3, R4)
    for (int i = 0; i < NVEC; i++) begin
      cal_window(WIN_LEN[i]);
      wait_tick(t0);
      @(negedge clk);
      check(ratio == 4'(WIN_EXP[i]), "R3 R4 measured ratio", int'(ratio), WIN_EXP[i]);
      if (i == 5) begin
        wait_tick(t1);
        wait_tick(t2);
        check(t2 - t1 == 3 * BASE, "R7 period ratio 3", t2 - t1, 3 * BASE);
      end
    end

    // R8: the frame in progress keeps the old ratio (15)
    wait_tick(t0);
    @(negedge clk);
    cal_window(64);
    check(ratio == 4'd15, "R8 ratio held mid-frame", int'(ratio), 15);
    wait_tick(t1);
    check(t1 - t0 == 15 * BASE, "R8 old frame length", t1 - t0, 15 * BASE);
    @(negedge clk);
    check(ratio == 4'd4, "R8 ratio after boundary", int'(ratio), 4);
    wait_tick(t2);
    check(t2 - t1 == 4 * BASE, "R7 R8 new frame length", t2 - t1, 4 * BASE);

    // R5 and R9: start refused in power-down, held enable does not retry
    @(negedge clk);
    pwr_down = 1'b1;
    cal_en   = 1'b1;
    @(negedge clk);
    check(cal_busy == 1'b0, "R5 refused start", int'(cal_busy), 0);
    repeat (20) @(negedge clk);
    pwr_down = 1'b0;
    repeat (100) @(negedge clk);
    check(cal_busy == 1'b0, "R9 no start on held enable", int'(cal_busy), 0);
    cal_en = 1'b0;
    wait_tick(t0);
    @(negedge clk);
    check(ratio == 4'd4, "R5 R9 ratio unchanged", int'(ratio), 4);

    // R6: abort by partial-screen mode mid-window
    cal_en = 1'b1;
    repeat (100) @(negedge clk);
    check(cal_busy == 1'b1, "R6 window open", int'(cal_busy), 1);
    partial_mode = 1'b1;
    @(negedge clk);
    check(cal_busy == 1'b0, "R6 aborted", int'(cal_busy), 0);
    partial_mode = 1'b0;
    repeat (50) @(negedge clk);
    cal_en = 1'b0;
    wait_tick(t0);
    @(negedge clk);
    check(ratio == 4'd4, "R6 previous ratio kept", int'(ratio), 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule